// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This block computes the destination value of one integer operation for a register machine with 64-bit registers. Each accepted request carries a four-bit operation code, a width bit that picks 64-bit or 32-bit arithmetic, a bit that picks the second operand from either the register value or a 32-bit immediate, a 16-bit offset field and the two register values. One clock edge later the block presents the new destination value.

The unit covers add, subtract, negate, the three bitwise logic operations, three kinds of shift, multiply, unsigned and signed divide and modulo, and plain and sign-extending moves. Narrow (32-bit) operations work only on the low halves of their operands and always return a result with the upper half cleared. Signed divide, signed modulo and the sign-extending move share their codes with the plain forms. A non-zero offset field selects them. Overflow wraps silently. There are no flags and no traps, and division by zero returns a defined value.

Top module: `dual_width_alu`

## Requirements
- R1: When the width bit is 0, both operands are cut to their low 32 bits and the result is the 32-bit answer with bits 63:32 cleared. When it is 1, full 64-bit operands are used.
- R2: Operation codes: 0x0 add, 0x1 subtract (dst minus src), 0x2 multiply, 0x3 divide, 0x4 or, 0x5 and, 0x6 left shift, 0x7 logical right shift, 0x8 negate, 0x9 modulo, 0xA xor, 0xB move, 0xC arithmetic right shift. Codes 0xD to 0xF return dst, cut to the selected width.
- R3: Add, subtract, multiply and negate wrap modulo 2^64 or 2^32 without any other effect.
- R4: The shift count is the source ANDed with 0x3F in 64-bit mode and with 0x1F in 32-bit mode. The arithmetic right shift copies the sign bit of the selected width.
- R5: Divide and modulo are unsigned when the offset field is 0 and signed when it is non-zero.
- R6: The signed quotient truncates toward zero. The signed remainder is a - n*trunc(a/n) and takes the sign of the dividend, so -13 mod 3 = -1.
- R7: A zero divisor makes divide return 0, and makes modulo return dst (in 32-bit mode, the zero-extended low 32 bits of dst).
- R8: Signed divide of the most negative value of the width by -1 returns that most negative value. The matching signed modulo returns 0.
- R9: Move with offset 8 or 16 sign-extends the low 8 or 16 source bits to the selected width. In 64-bit mode, offset 32 sign-extends the low 32 bits. Any other offset copies the source.
- R10: When the immediate is selected it replaces the source register. In 64-bit mode it is sign-extended from bit 31. In 32-bit mode it is used as-is.
- R11: Negate returns 0 - dst, and the source register and immediate have no effect on it.
- R12: The result and a valid flag appear on the first rising edge after a request with in_valid high. Without a request the result holds and the valid flag is low. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 4 | Operation code (R2) |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| use_imm | input | 1 | 1 = immediate replaces the source register |
| offset | input | 16 | Variant selector for divide, modulo and move |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| res_valid | output | 1 | Result registered from the previous request |
| result | output | 64 | New destination value |

## Verification
Immediate extension and signed division can apply to the same request. A negative immediate used as a signed divisor in 64-bit mode must be sign-extended before its magnitude is taken. The same immediate in 32-bit mode must not be. The bench creates this overlap with directed divide and modulo requests that carry negative immediates and non-zero offsets in both widths. It also produces many more through random mixes of width, immediate selection and offset. Every result is compared against a bench model that extends the operand first and then applies truncating signed division, with the zero-divisor and overflow cases handled on their own.

// File: rtl/dual_width_alu_pkg.sv
package dual_width_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_MUL  = 4'h2,
      OP_DIV  = 4'h3,
      OP_OR   = 4'h4,
      OP_AND  = 4'h5,
      OP_SHL  = 4'h6,
      OP_SHR  = 4'h7,
      OP_NEG  = 4'h8,
      OP_MOD  = 4'h9,
      OP_XOR  = 4'hA,
      OP_MOV  = 4'hB,
      OP_SAR  = 4'hC
   } alu_op_e;
endpackage

// File: rtl/alu_divider.sv
module alu_divider #(
   parameter int W = 64
) (
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   input  logic         is_signed,
   output logic [W-1:0] quot,
   output logic [W-1:0] rem
);
   localparam logic [W-1:0] ZERO = '0;

   logic          a_neg, b_neg;
   logic [W-1:0]  mag_a, mag_b, uq, ur;
   logic          div_zero;

   if (W < 8) begin : g_bad_width
      $error("alu_divider: width too small");
   end

   always_comb begin
      a_neg    = is_signed & dividend[W-1];
      b_neg    = is_signed & divisor[W-1];
      mag_a    = a_neg ? (ZERO - dividend) : dividend;
      mag_b    = b_neg ? (ZERO - divisor)  : divisor;
      div_zero = (divisor == ZERO);
      if (div_zero) begin
         uq = ZERO;
         ur = ZERO;
      end else begin
         uq = mag_a / mag_b;
         ur = mag_a % mag_b;
      end
      // The magnitude of the most negative value is itself as unsigned,
      // so MIN / -1 gives MIN again and the remainder is zero.
      if (div_zero) begin
         quot = ZERO;
         rem  = dividend;
      end else begin
         quot = (a_neg ^ b_neg) ? (ZERO - uq) : uq;
         rem  = a_neg ? (ZERO - ur) : ur;
      end
   end

   always_comb begin
      if (!div_zero) begin
         // R6
         div_identity_chk: assert (quot * divisor + rem == dividend);
         // R6
         rem_bound_chk: assert (ur < mag_b);
         // R6
         rem_sign_chk: assert (rem == ZERO || !is_signed || rem[W-1] == dividend[W-1]);
      end
   end
endmodule

// File: rtl/alu_lane.sv
module alu_lane
   import dual_width_alu_pkg::*;
#(
   parameter int W     = 64,
   parameter int OFF_W = 16
) (
   input  logic [3:0]       op,
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [OFF_W-1:0] offset,
   output logic [W-1:0]     y
);
   localparam int SH_W = $clog2(W);
   localparam logic [W-1:0] ZERO = '0;

   logic             variant;
   logic [SH_W-1:0]  shamt;
   logic [W-1:0]     quot, rem;
   logic [W-1:0]     mv8, mv16, mv32, mv_res;

   if (W != 32 && W != 64) begin : g_bad_width
      $error("alu_lane: width must be 32 or 64");
   end

   assign variant = (offset != '0);
   assign shamt   = b[SH_W-1:0];

   alu_divider #(.W(W)) u_div (
      .dividend (a),
      .divisor  (b),
      .is_signed(variant),
      .quot     (quot),
      .rem      (rem)
   );

   assign mv8  = {{(W-8){b[7]}},  b[7:0]};
   assign mv16 = {{(W-16){b[15]}}, b[15:0]};

   if (W > 32) begin : g_mv32
      assign mv32 = {{(W-32){b[31]}}, b[31:0]};
   end else begin : g_no_mv32
      assign mv32 = b;
   end

   always_comb begin
      case (offset)
         OFF_W'(8):  mv_res = mv8;
         OFF_W'(16): mv_res = mv16;
         OFF_W'(32): mv_res = mv32;
         default:    mv_res = b;
      endcase
   end

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_MUL:  y = a * b;
         OP_DIV:  y = quot;
         OP_OR:   y = a | b;
         OP_AND:  y = a & b;
         OP_SHL:  y = a << shamt;
         OP_SHR:  y = a >> shamt;
         OP_NEG:  y = ZERO - a;
         OP_MOD:  y = rem;
         OP_XOR:  y = a ^ b;
         OP_MOV:  y = mv_res;
         OP_SAR:  y = W'($signed(a) >>> shamt);
         default: y = a;
      endcase
   end
endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
   import dual_width_alu_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int HALF  = 32,
   parameter int IMM_W = 32,
   parameter int OFF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [3:0]       op_code,
   input  logic             wide,
   input  logic             use_imm,
   input  logic [15:0]      offset,
   input  logic [63:0]      dst_val,
   input  logic [63:0]      src_val,
   input  logic [31:0]      imm,
   output logic             res_valid,
   output logic [63:0]      result
);
   if (XLEN != 2 * HALF) begin : g_bad_half
      $error("dual_width_alu: HALF must be half of XLEN");
   end
   if (IMM_W != HALF || XLEN != 64 || OFF_W != 16) begin : g_bad_port
      $error("dual_width_alu: port widths are fixed at 64/32/16");
   end

   logic [XLEN-1:0] imm_ext, opnd_b;
   logic [XLEN-1:0] y_wide;
   logic [HALF-1:0] y_narrow;
   logic [XLEN-1:0] y_next;

   always_comb begin
      imm_ext = wide ? {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm}
                     : {{(XLEN-IMM_W){1'b0}}, imm};
      opnd_b  = use_imm ? imm_ext : src_val;
   end

   alu_lane #(.W(XLEN), .OFF_W(OFF_W)) u_lane_wide (
      .op    (op_code),
      .a     (dst_val),
      .b     (opnd_b),
      .offset(offset),
      .y     (y_wide)
   );

   alu_lane #(.W(HALF), .OFF_W(OFF_W)) u_lane_narrow (
      .op    (op_code),
      .a     (dst_val[HALF-1:0]),
      .b     (opnd_b[HALF-1:0]),
      .offset(offset),
      .y     (y_narrow)
   );

   assign y_next = wide ? y_wide : {{(XLEN-HALF){1'b0}}, y_narrow};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         result    <= '0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) result <= y_next;
      end
   end

   // R1
   narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !wide) |=> (result[XLEN-1:HALF] == '0));
   // R12
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);
   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!res_valid && $stable(result)));
   // R11
   negate_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && wide && op_code == OP_NEG) |=> (result + $past(dst_val) == '0));
endmodule

// File: tb/dual_width_alu_test.sv
`timescale 1ns/1ps
module dual_width_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        wide = 1'b0;
   logic        use_imm = 1'b0;
   logic [15:0] offset = '0;
   logic [63:0] dst_val = '0;
   logic [63:0] src_val = '0;
   logic [31:0] imm = '0;
   logic        res_valid;
   logic [63:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dual_width_alu uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .wide(wide), .use_imm(use_imm), .offset(offset), .dst_val(dst_val),
      .src_val(src_val), .imm(imm), .res_valid(res_valid), .result(result)
   );

   localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
   localparam logic [31:0] MIN32 = 32'h8000_0000;

   function automatic logic [63:0] model(input logic [3:0] op, input logic w,
         input logic ui, input logic [15:0] off, input logic [63:0] d,
         input logic [63:0] s, input logic [31:0] im);
      logic [63:0] b, a64, r64;
      logic [31:0] a32, b32, r32;
      b = ui ? (w ? {{32{im[31]}}, im} : {32'b0, im}) : s;
      if (w) begin
         a64 = d;
         case (op)
            4'h0: r64 = a64 + b;
            4'h1: r64 = a64 - b;
            4'h2: r64 = a64 * b;
            4'h3: if (b == 0) r64 = 0;
                  else if (off == 0) r64 = a64 / b;
                  else if (a64 == MIN64 && b == '1) r64 = MIN64;
                  else r64 = $signed(a64) / $signed(b);
            4'h4: r64 = a64 | b;
            4'h5: r64 = a64 & b;
            4'h6: r64 = a64 << b[5:0];
            4'h7: r64 = a64 >> b[5:0];
            4'h8: r64 = 64'd0 - a64;
            4'h9: if (b == 0) r64 = a64;
                  else if (off == 0) r64 = a64 % b;
                  else if (a64 == MIN64 && b == '1) r64 = 0;
                  else r64 = $signed(a64) % $signed(b);
            4'hA: r64 = a64 ^ b;
            4'hB: r64 = (off == 8)  ? {{56{b[7]}}, b[7:0]} :
                        (off == 16) ? {{48{b[15]}}, b[15:0]} :
                        (off == 32) ? {{32{b[31]}}, b[31:0]} : b;
            4'hC: r64 = $signed(a64) >>> b[5:0];
            default: r64 = a64;
         endcase
         return r64;
      end
      a32 = d[31:0];
      b32 = b[31:0];
      case (op)
         4'h0: r32 = a32 + b32;
         4'h1: r32 = a32 - b32;
         4'h2: r32 = a32 * b32;
         4'h3: if (b32 == 0) r32 = 0;
               else if (off == 0) r32 = a32 / b32;
               else if (a32 == MIN32 && b32 == '1) r32 = MIN32;
               else r32 = $signed(a32) / $signed(b32);
         4'h4: r32 = a32 | b32;
         4'h5: r32 = a32 & b32;
         4'h6: r32 = a32 << b32[4:0];
         4'h7: r32 = a32 >> b32[4:0];
         4'h8: r32 = 32'd0 - a32;
         4'h9: if (b32 == 0) r32 = a32;
               else if (off == 0) r32 = a32 % b32;
               else if (a32 == MIN32 && b32 == '1) r32 = 0;
               else r32 = $signed(a32) % $signed(b32);
         4'hA: r32 = a32 ^ b32;
         4'hB: r32 = (off == 8)  ? {{24{b32[7]}}, b32[7:0]} :
                     (off == 16) ? {{16{b32[15]}}, b32[15:0]} : b32;
         4'hC: r32 = $signed(a32) >>> b32[4:0];
         default: r32 = a32;
      endcase
      return {32'b0, r32};
   endfunction

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'h0, 4'h1, 4'h2: return "R3";
         4'h3, 4'h9:       return "R5";
         4'h6, 4'h7, 4'hC: return "R4";
         4'h8:             return "R11";
         4'hB:             return "R9";
         default:          return "R2";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input logic w, input logic ui,
         input logic [15:0] off, input logic [63:0] d, input logic [63:0] s,
         input logic [31:0] im);
      @(negedge clk);
      op_code = op; wide = w; use_imm = ui; offset = off;
      dst_val = d; src_val = s; imm = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run(input string req, input logic [3:0] op, input logic w,
         input logic ui, input logic [15:0] off, input logic [63:0] d,
         input logic [63:0] s, input logic [31:0] im, input logic [63:0] exp);
      issue(op, w, ui, off, d, s, im);
      check(req, result, exp);
      check("R12", {63'b0, res_valid}, 64'd1);
   endtask

   function automatic logic [63:0] pick64();
      case ($urandom % 6)
         0: return MIN64;
         1: return '1;
         2: return 64'(($urandom % 7));
         3: return {32'h0, MIN32};
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] r, prev;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", result, 64'd0);
      check("R12", {63'b0, res_valid}, 64'd0);
      rst_n = 1'b1;

      // R6: -13 mod 3 = -1, signed variant, both widths
      run("R6", 4'h9, 1'b1, 1'b0, 16'd1, -64'sd13, 64'd3, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      run("R6", 4'h9, 1'b0, 1'b0, 16'd1, {32'hDEAD_BEEF, 32'hFFFF_FFF3}, 64'd3, 32'd0, 64'h0000_0000_FFFF_FFFF);
      run("R6", 4'h3, 1'b1, 1'b0, 16'd1, -64'sd13, 64'd3, 32'd0, 64'hFFFF_FFFF_FFFF_FFFC);
      // R5: offset 0 gives unsigned division of the same bits
      run("R5", 4'h3, 1'b0, 1'b0, 16'd0, 64'hFFFF_FFF3, 64'd3, 32'd0, 64'h5555_5551);
      // R8: MIN / -1
      run("R8", 4'h3, 1'b1, 1'b0, 16'd1, MIN64, '1, 32'd0, MIN64);
      run("R8", 4'h9, 1'b1, 1'b0, 16'd1, MIN64, '1, 32'd0, 64'd0);
      run("R8", 4'h3, 1'b0, 1'b0, 16'd5, {32'h1, MIN32}, 64'hFFFF_FFFF, 32'd0, {32'h0, MIN32});
      // R7: zero divisor
      run("R7", 4'h3, 1'b1, 1'b0, 16'd0, 64'h1234, 64'd0, 32'd0, 64'd0);
      run("R7", 4'h9, 1'b1, 1'b0, 16'd1, 64'hABCD_0000_1234_5678, 64'd0, 32'd0, 64'hABCD_0000_1234_5678);
      run("R7", 4'h9, 1'b0, 1'b0, 16'd0, 64'hABCD_0000_1234_5678, 64'hFFFF_FFFF_0000_0000, 32'd0, 64'h1234_5678);
      // R4: masked shift counts
      run("R4", 4'h6, 1'b1, 1'b0, 16'd0, 64'd1, 64'd65, 32'd0, 64'd2);
      run("R4", 4'h6, 1'b0, 1'b0, 16'd0, 64'd1, 64'd33, 32'd0, 64'd2);
      run("R4", 4'hC, 1'b0, 1'b0, 16'd0, 64'h8000_0000, 64'd4, 32'd0, 64'hF800_0000);
      run("R4", 4'hC, 1'b1, 1'b0, 16'd0, MIN64, 64'd63, 32'd0, '1);
      // R10: immediate extension
      run("R10", 4'h0, 1'b1, 1'b1, 16'd0, 64'd10, 64'd999, 32'hFFFF_FFFF, 64'd9);
      run("R10", 4'h0, 1'b0, 1'b1, 16'd0, 64'd10, 64'd999, 32'hFFFF_FFFF, 64'd9);
      run("R10", 4'h4, 1'b1, 1'b1, 16'd0, 64'd0, 64'd0, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000);
      // R10 with R5: negative immediate as signed divisor
      run("R10", 4'h3, 1'b1, 1'b1, 16'd1, 64'd100, 64'd0, 32'hFFFF_FFF9, -64'sd14);
      run("R10", 4'h3, 1'b0, 1'b1, 16'd1, 64'd100, 64'd0, 32'hFFFF_FFF9, 64'hFFFF_FFF2);
      // R9: sign-extending moves
      run("R9", 4'hB, 1'b1, 1'b0, 16'd8, 64'd0, 64'h1234_0080, 32'd0, 64'hFFFF_FFFF_FFFF_FF80);
      run("R9", 4'hB, 1'b0, 1'b0, 16'd16, 64'd0, 64'h1234_8001, 32'd0, 64'h0000_0000_FFFF_8001);
      run("R9", 4'hB, 1'b1, 1'b0, 16'd32, 64'd0, 64'h1_8000_0000, 32'd0, 64'hFFFF_FFFF_8000_0000);
      run("R9", 4'hB, 1'b0, 1'b0, 16'd32, 64'd0, 64'h1_8000_0000, 32'd0, 64'h8000_0000);
      run("R9", 4'hB, 1'b1, 1'b0, 16'd0, 64'd0, 64'h1234_0080, 32'd0, 64'h1234_0080);
      // R11: negate ignores source and immediate
      run("R11", 4'h8, 1'b1, 1'b1, 16'd0, 64'd5, 64'd77, 32'h1234, -64'sd5);
      run("R11", 4'h8, 1'b0, 1'b0, 16'd0, 64'h7_0000_0005, 64'd77, 32'd0, 64'hFFFF_FFFB);
      // R3: wrap
      run("R3", 4'h0, 1'b1, 1'b0, 16'd0, '1, 64'd2, 32'd0, 64'd1);
      run("R3", 4'h1, 1'b0, 1'b0, 16'd0, 64'd0, 64'd1, 32'd0, 64'hFFFF_FFFF);
      // R1: narrow operation ignores upper operand bits
      run("R1", 4'hA, 1'b0, 1'b0, 16'd0, 64'hFFFF_0000_0000_00F0, 64'hAAAA_0000_0000_000F, 32'd0, 64'hFF);
      // R2: reserved code returns dst
      run("R2", 4'hE, 1'b1, 1'b0, 16'd0, 64'h0123_4567_89AB_CDEF, 64'd1, 32'd0, 64'h0123_4567_89AB_CDEF);
      run("R2", 4'hF, 1'b0, 1'b0, 16'd0, 64'h0123_4567_89AB_CDEF, 64'd1, 32'd0, 64'h89AB_CDEF);

      // R12: idle cycles hold the result and drop valid
      prev = result;
      @(negedge clk);
      op_code = 4'h0; dst_val = '1; src_val = '1;
      @(negedge clk);
      check("R12", result, prev);
      check("R12", {63'b0, res_valid}, 64'd0);

      // random mix over all codes, widths and variants
      for (int i = 0; i < 600; i++) begin
         logic [3:0]  op;
         logic        w, ui;
         logic [15:0] off;
         logic [63:0] d, s;
         logic [31:0] im;
         op = 4'($urandom % 16);
         w  = 1'($urandom % 2);
         ui = 1'($urandom % 2);
         case ($urandom % 6)
            0: off = 16'd8;
            1: off = 16'd16;
            2: off = 16'd32;
            3: off = 16'($urandom);
            default: off = 16'd0;
         endcase
         d  = pick64();
         s  = ($urandom % 5 == 0) ? 64'd0 : pick64();
         im = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
         r  = model(op, w, ui, off, d, s, im);
         issue(op, w, ui, off, d, s, im);
         check(tag_of(op), result, r);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule